// File: doc/BRIEF.md
# Link Bring-Up Sequencer with Speed Fallback

This block drives the bring-up of a serial link. After a start pulse it holds the fundamental-reset output (active low) asserted with training disabled. It then releases reset and waits a settle interval. After that it enables training at the highest allowed generation and pulses a retrain request. It polls the training state machine's state code for link-up a bounded number of times, with a fixed wait between polls. When an attempt times out, it drops the requested generation by one and tries again, and it gives up after generation 1 fails. When the link comes up below the requested generation, it trains once more at the negotiated generation. It reports success only when the negotiated generation equals the one requested in the last attempt.

All delays are counted in ticks of one free-running prescaler. The tick period and every interval length are parameters, so a bench can run the full sequence in a few hundred cycles. The partner state machine and the PHY lie outside the block.

States and transitions: `ST_IDLE` (after reset) and the terminal states `ST_DONE` / `ST_FAIL` go to `ST_PERST` on `start_i`. `ST_PERST` goes to `ST_SETTLE` when the reset interval expires. `ST_SETTLE` goes to `ST_ARM` when the settle interval expires. `ST_ARM` (one cycle: training on, retrain pulse) always goes to `ST_CHECK`. From `ST_CHECK` there are five exits:
- link up and negotiated generation equal to the request: `ST_DONE`.
- link up and negotiated generation lower, during the first pass: back to `ST_ARM` for the repeat pass.
- link up with any other result: `ST_FAIL`.
- link not up with polls remaining: `ST_WAIT`.
- link not up with polls exhausted: `ST_ARM` one generation lower, or `ST_FAIL` if the request was already generation 1 or this was the repeat pass.

`ST_WAIT` returns to `ST_CHECK` when the poll interval expires.

Top module: `link_bringup_seq`

## Requirements
- R1: On an accepted start, `perst_n_o` goes low for RST_TICKS prescaler ticks. `train_en_o` stays low whenever `perst_n_o` is low.
- R2: After `perst_n_o` returns high, `train_en_o` stays low for SETTLE_TICKS ticks before the first attempt.
- R3: `gen_sel_o` carries the generation number (1, 2 or 3). The first attempt uses `max_gen_i`. A `max_gen_i` of 0 selects DEF_GEN (default 3).
- R4: Each attempt raises or keeps `train_en_o` high and issues a one-cycle `retrain_o` pulse. The number of pulses per run equals the number of attempts.
- R5: The link counts as up when `ltssm_i` >= 0x10 (0x0F is not up). It is checked up to POLL_TRIES times with POLL_TICKS ticks between checks. If every check misses, the attempt fails.
- R6: A failed attempt lowers `gen_sel_o` by one and retries without reasserting `perst_n_o`. When the generation 1 attempt fails, the block ends in the fail state.
- R7: If the link comes up with `neg_gen_i` (nonzero) below the request during the first pass, exactly one repeat attempt runs at `neg_gen_i`. A run succeeds only if the final `neg_gen_i` equals the final request. A negotiated generation above the request fails.
- R8: `done_o` and `fail_o` are never high together. Each of them, and `gen_sel_o`, stays unchanged until the next `start_i`.
- R9: `start_i` is ignored while a sequence is in progress.
- R10: After reset: `perst_n_o`=1, `train_en_o`=0, `retrain_o`=0, `done_o`=0, `fail_o`=0, `gen_sel_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up run (accepted only when idle or finished) |
| max_gen_i | input | 2 | Highest generation allowed; 0 selects the default |
| ltssm_i | input | LTSSM_W | Current training state code |
| neg_gen_i | input | 2 | Negotiated generation reported by the link |
| gen_sel_o | output | 2 | Requested generation |
| train_en_o | output | 1 | Training enable |
| retrain_o | output | 1 | One-cycle retrain request |
| perst_n_o | output | 1 | Fundamental reset to the partner, active low |
| done_o | output | 1 | Run succeeded |
| fail_o | output | 1 | Run failed |

## Verification
The bench builds the block with PRESCALE=4, RST_TICKS=3, SETTLE_TICKS=5, POLL_TICKS=2 and POLL_TRIES=3. With these values a complete run, including every timeout on the way down to generation 1, lasts about a hundred cycles. That makes it practical to sweep every allowed maximum (including the out-of-range 0) against every partner speed cap and every highest trainable generation, plus partners that report too high a speed. A behavioural partner holds the state code at 0x0F before reporting 0x10. The bench computes the outcome, the final generation and the attempt count arithmetically. It also brackets the reset, settle and timeout windows by tick arithmetic.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef logic [1:0] gen_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PERST,
        ST_SETTLE,
        ST_ARM,
        ST_CHECK,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } state_t;

    typedef enum logic [1:0] {
        V_DONE,
        V_REPEAT,
        V_FAIL
    } verdict_t;

endpackage

// File: rtl/lbs_tick.sv
// Free-running prescaler: one tick_o pulse every PRESCALE cycles.
module lbs_tick #(
    parameter int PRESCALE = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(PRESCALE);
            localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              cnt_q <= '0;
                else if (cnt_q == LAST)  cnt_q <= '0;
                else                     cnt_q <= cnt_q + 1'b1;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/lbs_timer.sv
// Tick-based interval timer: load sets the length, expiry is a zero count.
module lbs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load_i)                 cnt_q <= len_i;
        else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R2: an expired timer stays expired until it is reloaded (no wrap).
    assert_timer_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/lbs_judge.sv
// Decides what a link-up observation means for the current attempt.
module lbs_judge (
    input  logic              second_i,
    input  lbs_pkg::gen_t     cur_i,
    input  lbs_pkg::gen_t     neg_i,
    output lbs_pkg::verdict_t verdict_o
);
    always_comb begin
        if (neg_i == cur_i)
            verdict_o = lbs_pkg::V_DONE;
        else if (!second_i && neg_i != 2'd0 && neg_i < cur_i)
            verdict_o = lbs_pkg::V_REPEAT;
        else
            verdict_o = lbs_pkg::V_FAIL;
    end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
    parameter int PRESCALE     = 100000,
    parameter int RST_TICKS    = 10,
    parameter int SETTLE_TICKS = 100,
    parameter int POLL_TICKS   = 95,
    parameter int POLL_TRIES   = 10,
    parameter int DEF_GEN      = 3,
    parameter int LTSSM_W      = 6,
    parameter int L0_CODE      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         max_gen_i,
    input  logic [LTSSM_W-1:0] ltssm_i,
    input  logic [1:0]         neg_gen_i,
    output logic [1:0]         gen_sel_o,
    output logic               train_en_o,
    output logic               retrain_o,
    output logic               perst_n_o,
    output logic               done_o,
    output logic               fail_o
);
    import lbs_pkg::*;

    localparam int MAXT = (RST_TICKS > SETTLE_TICKS)
                        ? ((RST_TICKS > POLL_TICKS) ? RST_TICKS : POLL_TICKS)
                        : ((SETTLE_TICKS > POLL_TICKS) ? SETTLE_TICKS : POLL_TICKS);
    localparam int TW = $clog2(MAXT + 1);
    localparam int NW = (POLL_TRIES > 1) ? $clog2(POLL_TRIES) : 1;
    localparam logic [TW-1:0] RST_LEN    = TW'(RST_TICKS);
    localparam logic [TW-1:0] SETTLE_LEN = TW'(SETTLE_TICKS);
    localparam logic [TW-1:0] POLL_LEN   = TW'(POLL_TICKS);
    localparam logic [NW-1:0] LAST_TRY   = NW'(POLL_TRIES - 1);
    localparam gen_t          DEF_G      = gen_t'(DEF_GEN);

    state_t          st_q, st_nx;
    gen_t            gen_q, gen_nx, start_gen;
    logic            second_q, second_nx;
    logic [NW-1:0]   tries_q, tries_nx;
    logic            tick, tmr_load, tmr_done, link_up;
    logic [TW-1:0]   tmr_len;
    verdict_t        vd;

    lbs_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    lbs_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(tmr_load),
        .len_i(tmr_len), .expired_o(tmr_done)
    );

    lbs_judge u_judge (
        .second_i(second_q), .cur_i(gen_q), .neg_i(neg_gen_i), .verdict_o(vd)
    );

    assign link_up   = (ltssm_i >= LTSSM_W'(L0_CODE));
    assign start_gen = (max_gen_i == 2'd0) ? DEF_G : max_gen_i;

    // Next-state and bookkeeping of the current attempt.
    always_comb begin
        st_nx     = st_q;
        gen_nx    = gen_q;
        second_nx = second_q;
        tries_nx  = tries_q;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    st_nx     = ST_PERST;
                    gen_nx    = start_gen;
                    second_nx = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_len   = RST_LEN;
                end
            end
            ST_PERST: begin
                if (tmr_done) begin
                    st_nx    = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_len  = SETTLE_LEN;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) st_nx = ST_ARM;
            end
            ST_ARM: begin
                tries_nx = '0;
                st_nx    = ST_CHECK;
            end
            ST_CHECK: begin
                if (link_up) begin
                    unique case (vd)
                        V_DONE:   st_nx = ST_DONE;
                        V_REPEAT: begin
                            gen_nx    = neg_gen_i;
                            second_nx = 1'b1;
                            st_nx     = ST_ARM;
                        end
                        default:  st_nx = ST_FAIL;
                    endcase
                end else if (tries_q == LAST_TRY) begin
                    if (second_q || gen_q == 2'd1) begin
                        st_nx = ST_FAIL;
                    end else begin
                        gen_nx = gen_q - 2'd1;
                        st_nx  = ST_ARM;
                    end
                end else begin
                    tries_nx = tries_q + 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = POLL_LEN;
                    st_nx    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tmr_done) st_nx = ST_CHECK;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            gen_q    <= 2'd0;
            second_q <= 1'b0;
            tries_q  <= '0;
        end else begin
            st_q     <= st_nx;
            gen_q    <= gen_nx;
            second_q <= second_nx;
            tries_q  <= tries_nx;
        end
    end

    // Outputs.
    always_comb begin
        perst_n_o  = 1'b1;
        train_en_o = 1'b0;
        retrain_o  = 1'b0;
        done_o     = 1'b0;
        fail_o     = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_SETTLE: ;
            ST_PERST: perst_n_o = 1'b0;
            ST_ARM: begin
                train_en_o = 1'b1;
                retrain_o  = 1'b1;
            end
            ST_CHECK, ST_WAIT: train_en_o = 1'b1;
            ST_DONE: begin
                train_en_o = 1'b1;
                done_o     = 1'b1;
            end
            ST_FAIL: begin
                train_en_o = 1'b1;
                fail_o     = 1'b1;
            end
            default: ;
        endcase
    end
    assign gen_sel_o = gen_q;

    assert_no_train_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !perst_n_o |-> !train_en_o);
    assert_retrain_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_o |-> train_en_o);
    assert_retrain_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retrain_o |=> !retrain_o);
    assert_gen_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        train_en_o |-> (gen_sel_o != 2'd0));
    assert_gen_only_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en_o && $past(train_en_o) && gen_sel_o != $past(gen_sel_o))
        |-> (gen_sel_o < $past(gen_sel_o)));
    assert_outcome_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(gen_sel_o)));
    assert_fail_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && $stable(gen_sel_o)));
endmodule

// File: tb/link_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module link_bringup_seq_tb_top;
    localparam int P  = 4;
    localparam int RT = 3;
    localparam int SE = 5;
    localparam int PT = 2;
    localparam int TR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] max_gen = 2'd0;
    logic [5:0] ltssm = 6'd0;
    logic [1:0] neg = 2'd0;
    logic [1:0] gen_sel;
    logic       train_en, retrain, perst_n, done, fail;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    link_bringup_seq #(
        .PRESCALE(P), .RST_TICKS(RT), .SETTLE_TICKS(SE),
        .POLL_TICKS(PT), .POLL_TRIES(TR), .DEF_GEN(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .max_gen_i(max_gen),
        .ltssm_i(ltssm), .neg_gen_i(neg), .gen_sel_o(gen_sel),
        .train_en_o(train_en), .retrain_o(retrain), .perst_n_o(perst_n),
        .done_o(done), .fail_o(fail)
    );

    // Behavioural partner and measurement.
    int   m_cap = 3, m_maxok = 3;
    bit   m_over = 0;
    bit   armed = 0;
    int   acnt = 0;
    int   at_gen = 0;
    int   first_gen = 0;
    int   n_retrain = 0, perst_cyc = 0, settle_cyc = 0, fail_lat = 0;
    bit   seen_perst = 0, lat_on = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (retrain) begin
                if (n_retrain == 0) first_gen = int'(gen_sel);
                n_retrain++;
                ltssm  = 6'h05;
                neg    = 2'd0;
                armed  = 1;
                acnt   = 0;
                at_gen = int'(gen_sel);
                lat_on = 1;
                fail_lat = 0;
            end else if (armed) begin
                acnt++;
                if (at_gen <= m_maxok) begin
                    if (acnt == 1) ltssm = 6'h0F;
                    if (acnt == 6) begin
                        ltssm = 6'h10;
                        neg   = m_over ? 2'd3 : 2'((at_gen < m_cap) ? at_gen : m_cap);
                        armed = 0;
                    end
                end
            end
            if (!perst_n) begin
                perst_cyc++;
                seen_perst = 1;
            end
            if (seen_perst && perst_n && !train_en) settle_cyc++;
            if (lat_on) begin
                fail_lat++;
                if (done || fail) lat_on = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int mg, input int cap, input int mok, input bit ov, input bit poke);
        int g, att, fg, n;
        bit dn, rep, tmo;
        string t_out;
        // expected result from the requirements
        g = (mg == 0) ? 3 : mg;
        att = 0; fg = 0; dn = 0; rep = 0; tmo = 0;
        while (1) begin
            att++;
            if (g <= mok) begin
                n = ov ? 3 : ((g < cap) ? g : cap);
                if (n == g) begin dn = 1; fg = g; break; end
                else if (n < g) begin att++; rep = 1; dn = 1; fg = n; break; end
                else begin dn = 0; break; end
            end else begin
                if (g == 1) begin dn = 0; tmo = 1; break; end
                g--;
            end
        end
        m_cap = cap; m_maxok = mok; m_over = ov;
        n_retrain = 0; perst_cyc = 0; settle_cyc = 0; seen_perst = 0; first_gen = 0;

        @(negedge clk); start = 1'b1; max_gen = 2'(mg);
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (12) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done || fail) break;
        end
        t_out = poke ? "R9" : (rep || ov) ? "R7" : "R6";
        chk(done == dn && fail == !dn, t_out, int'(done), int'(dn));
        chk(first_gen == ((mg == 0) ? 3 : mg), "R3 first generation", first_gen, (mg == 0) ? 3 : mg);
        if (dn) chk(int'(gen_sel) == fg, rep ? "R7 final generation" : "R3 final generation", int'(gen_sel), fg);
        chk(n_retrain == att, poke ? "R9 attempts" : "R4 attempts", n_retrain, att);
        chk(perst_cyc >= (RT-1)*P+2 && perst_cyc <= RT*P+1, poke ? "R9 reset width" : "R1 reset width",
            perst_cyc, RT*P);
        chk(settle_cyc >= (SE-1)*P+2 && settle_cyc <= SE*P+1, "R2 settle", settle_cyc, SE*P);
        if (tmo)
            chk(fail_lat >= 2 + (TR-1)*((PT-1)*P+3) && fail_lat <= 2 + (TR-1)*(PT*P+2),
                "R5 poll window", fail_lat, 2 + (TR-1)*(PT*P+2));
        begin
            int g0; bit d0, f0;
            g0 = int'(gen_sel); d0 = done; f0 = fail;
            repeat (15) @(negedge clk);
            chk(done == d0 && fail == f0 && int'(gen_sel) == g0 && !(done && fail),
                "R8 hold", int'(gen_sel), g0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (run hung)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(perst_n == 1'b1 && train_en == 1'b0 && retrain == 1'b0 &&
            done == 1'b0 && fail == 1'b0 && gen_sel == 2'd0,
            "R10 reset state", int'({perst_n, train_en, retrain, done, fail}), 16);
        for (int mg = 0; mg < 4; mg++)
            for (int cap = 1; cap < 4; cap++)
                for (int mok = 0; mok < 4; mok++)
                    run_case(mg, cap, mok, 1'b0, 1'b0);
        for (int mg = 1; mg < 4; mg++)
            run_case(mg, 3, 3, 1'b1, 1'b0);   // R7: partner reports too high
        run_case(3, 1, 3, 1'b0, 1'b1);        // R9: starts during run ignored
        run_case(2, 3, 0, 1'b0, 1'b1);        // R9 with full fallback
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule